// File: doc/BRIEF.md
# Online Spare Rank Controller

This block stands between a host memory request port and a group of active memory ranks plus one reserved spare rank. The ranks are modelled inside the block as small synchronous RAM arrays. For every active rank the block keeps a saturating count of correctable errors. Each read carries a correctable-error flag from an external checker, and that flag drives the count. A programmable threshold sets the limit.

When any rank's count rises above the threshold, the block acts without any software command. It stalls the host and copies every word of the failing rank into the spare rank. It then retires the failing rank and silently redirects all later accesses for it to the spare. The host keeps using the same rank and address numbers throughout, and the data it wrote earlier is still there.

The spare can be used only once. If another rank crosses the threshold after that, the block sets a sticky flag and does not migrate again.

Top module: `spare_rank_ctrl`

## Requirements
- R1: After reset, hostReady is 1 and ceAlert, spareUsed, spentFlag and hostRvalid are all 0.
- R2: A request is accepted on a rising edge where hostValid and hostReady are both 1. For an accepted read, hostRdata holds the word last written to the same rank and address, and hostRvalid is 1, in the cycle after acceptance. An accepted write stores hostWdata at that rank and address.
- R3: The error count of a rank goes up by one only for an accepted read to that rank with hostCe=1. Writes with hostCe=1 and reads with hostCe=0 leave the count unchanged.
- R4: Migration starts only when a count is strictly greater than the threshold. A count equal to the threshold starts nothing.
- R5: Error counts saturate at 2^CNT_W-1 and never wrap to a small value.
- R6: The threshold resets to THRESH_INIT. A cfgWe pulse loads cfgThreshold, and the new value is used from the next cycle on.
- R7: ceAlert rises one cycle after any count first exceeds the threshold and then stays high until reset.
- R8: Migration begins on the edge after the crossing is seen. hostReady is then 0 for exactly 2^ADDR_W+1 cycles, and during that time every word of the failing rank is copied to the spare.
- R9: After migration, spareUsed is 1 and failedRank holds the lowest-numbered rank that crossed. Accesses to that rank then reach the spare rank with all earlier data intact, and the other ranks are unaffected.
- R10: Only one migration ever happens. A crossing once the spare is in use sets spentFlag on the next edge, keeps it set, and causes no stall and no change to failedRank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hostValid | input | 1 | Host request present |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostRank | input | RANK_W | Logical active rank addressed |
| hostAddr | input | ADDR_W | Word address within the rank |
| hostWdata | input | DATA_W | Write data |
| hostCe | input | 1 | Correctable-error flag for this read |
| hostReady | output | 1 | Low while a migration copy runs |
| hostRdata | output | DATA_W | Read data |
| hostRvalid | output | 1 | hostRdata valid this cycle |
| cfgWe | input | 1 | Load the threshold |
| cfgThreshold | input | CNT_W | New threshold value |
| ceAlert | output | 1 | Sticky over-threshold notification |
| spareUsed | output | 1 | Failing rank has been retired to the spare |
| failedRank | output | RANK_W | Rank that was retired |
| spentFlag | output | 1 | Sticky: a crossing happened after the spare was used |

## Verification
Read data and hostRvalid are due one cycle after the acceptance edge. The bench drives inputs on falling edges and reads results on the falling edge that follows the acceptance edge.

A counted error becomes visible on the acceptance edge, and a new threshold on the cfgWe edge. The block reacts one edge later: ceAlert rises, or spentFlag sets, and hostReady drops. The bench therefore checks that hostReady is still 1 on the first falling edge after the trigger, and that the response is present on the second.

The stall length is counted falling edge by falling edge and compared against 2^ADDR_W+1. Data integrity after migration is checked against a bench model indexed by logical rank and address.

// File: rtl/spare_rank_pkg.sv
package spare_rank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COPY     = 2'd1,
    ST_SWITCHED = 2'd2
  } spareState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic copyRead;   // read the failing rank at copyRdAddr
    logic copyWrite;  // write the copy buffer into the spare at copyWrAddr
    logic remap;      // send the retired rank's traffic to the spare
  } ctlStrobe_t;

endpackage

// File: rtl/spare_ctl.sv
module spare_ctl
  import spare_rank_pkg::*;
#(
  parameter int NUM_RANKS   = 4,
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = 4,
  parameter int RANK_W      = 2,
  parameter int THRESH_INIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostAcc,
  input  logic              hostWrite,
  input  logic [RANK_W-1:0] hostRank,
  input  logic              hostCe,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgThreshold,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] copyRdAddr,
  output logic [ADDR_W-1:0] copyWrAddr,
  output logic [RANK_W-1:0] victim,
  output logic              hostReady,
  output logic              ceAlert,
  output logic              spareUsed,
  output logic              spentFlag
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ADDR_W:0] COPY_END = (ADDR_W+1)'(DEPTH);

  spareState_t       state;
  logic [ADDR_W:0]   copyCnt;
  logic [RANK_W-1:0] victimQ;
  logic [CNT_W-1:0]  thr;
  logic [CNT_W-1:0]  errCnt [NUM_RANKS];
  logic              alertQ, spentQ;
  logic              anyOver;
  logic [RANK_W-1:0] firstOver;
  logic              ceHit, copyDone, clearCnt;

  // lowest-numbered rank above threshold wins
  always_comb begin
    anyOver   = 1'b0;
    firstOver = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (errCnt[i] > thr) begin
        anyOver   = 1'b1;
        firstOver = RANK_W'(i);
      end
    end
  end

  assign ceHit    = hostAcc && !hostWrite && hostCe;
  assign copyDone = (state == ST_COPY) && (copyCnt == COPY_END);
  assign clearCnt = copyDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      copyCnt <= '0;
      victimQ <= '0;
      thr     <= CNT_W'(THRESH_INIT);
      alertQ  <= 1'b0;
      spentQ  <= 1'b0;
      for (int i = 0; i < NUM_RANKS; i++) errCnt[i] <= '0;
    end else begin
      if (cfgWe) thr <= cfgThreshold;
      for (int i = 0; i < NUM_RANKS; i++) begin
        if (clearCnt && victimQ == RANK_W'(i))
          errCnt[i] <= '0;
        else if (ceHit && hostRank == RANK_W'(i) && errCnt[i] != CNT_MAX)
          errCnt[i] <= errCnt[i] + CNT_W'(1);
      end
      alertQ <= alertQ | anyOver;
      case (state)
        ST_IDLE: begin
          if (anyOver) begin
            state   <= ST_COPY;
            victimQ <= firstOver;
            copyCnt <= '0;
          end
        end
        ST_COPY: begin
          copyCnt <= copyCnt + (ADDR_W+1)'(1);
          if (copyDone) state <= ST_SWITCHED;
        end
        ST_SWITCHED: begin
          if (anyOver) spentQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.copyRead  = (state == ST_COPY) && !copyCnt[ADDR_W];
  assign strobe.copyWrite = (state == ST_COPY) && (copyCnt != '0);
  assign strobe.remap     = (state == ST_SWITCHED);
  assign copyRdAddr = copyCnt[ADDR_W-1:0];
  assign copyWrAddr = copyCnt[ADDR_W-1:0] - ADDR_W'(1);
  assign victim     = victimQ;
  assign hostReady  = (state != ST_COPY);
  assign ceAlert    = alertQ;
  assign spareUsed  = (state == ST_SWITCHED);
  assign spentFlag  = spentQ;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : gSat
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (errCnt[g] == CNT_MAX && !(clearCnt && victimQ == RANK_W'(g))) |=> errCnt[g] == CNT_MAX); // R5
  end

  AST_ONE_FAILOVER: assert property (@(posedge clk) disable iff (rst)
    state == ST_SWITCHED |=> state == ST_SWITCHED); // R10
  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (rst)
    ceAlert |=> ceAlert); // R7
  AST_COPY_ALERTED: assert property (@(posedge clk) disable iff (rst)
    state == ST_COPY |-> ceAlert); // R7
  AST_VICTIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    state != ST_IDLE |=> $stable(victimQ)); // R9

endmodule

// File: rtl/spare_dp.sv
module spare_dp
  import spare_rank_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int RANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] copyRdAddr,
  input  logic [ADDR_W-1:0] copyWrAddr,
  input  logic [RANK_W-1:0] victim,
  input  logic              hostAcc,
  input  logic              hostWrite,
  input  logic [RANK_W-1:0] hostRank,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NPHYS  = NUM_RANKS + 1;
  localparam int PHYS_W = $clog2(NPHYS);
  localparam logic [PHYS_W-1:0] SPARE_IDX = PHYS_W'(NUM_RANKS);

  logic [DATA_W-1:0] mem [NPHYS][DEPTH];
  logic [DATA_W-1:0] copyBuf;
  logic [PHYS_W-1:0] physRank;

  assign physRank = (strobe.remap && hostRank == victim) ? SPARE_IDX : PHYS_W'(hostRank);

  always_ff @(posedge clk) begin
    if (hostAcc && hostWrite) mem[physRank][hostAddr] <= hostWdata;
    if (strobe.copyWrite)     mem[SPARE_IDX][copyWrAddr] <= copyBuf;
  end

  always_ff @(posedge clk) begin
    if (hostAcc && !hostWrite) hostRdata <= mem[physRank][hostAddr];
    if (strobe.copyRead)       copyBuf   <= mem[victim][copyRdAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) hostRvalid <= 1'b0;
    else     hostRvalid <= hostAcc && !hostWrite;
  end

  AST_NO_HOST_IN_COPY: assert property (@(posedge clk) disable iff (rst)
    !(hostAcc && (strobe.copyRead || strobe.copyWrite))); // R8
  AST_COPY_PIPE: assert property (@(posedge clk) disable iff (rst)
    strobe.copyWrite |-> $past(strobe.copyRead) || $past(strobe.copyWrite)); // R8
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (hostAcc && !hostWrite) |=> hostRvalid); // R2

endmodule

// File: rtl/spare_rank_ctrl.sv
module spare_rank_ctrl
  import spare_rank_pkg::*;
#(
  parameter int NUM_RANKS   = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 4,
  parameter int THRESH_INIT = 3,
  localparam int RANK_W     = $clog2(NUM_RANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [RANK_W-1:0] hostRank,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostCe,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgThreshold,
  output logic              ceAlert,
  output logic              spareUsed,
  output logic [RANK_W-1:0] failedRank,
  output logic              spentFlag
);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] copyRdAddr, copyWrAddr;
  logic [RANK_W-1:0] victim;
  logic              hostAcc;

  assign hostAcc    = hostValid && hostReady;
  assign failedRank = victim;

  spare_ctl #(
    .NUM_RANKS(NUM_RANKS), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .RANK_W(RANK_W), .THRESH_INIT(THRESH_INIT)
  ) u_ctl (
    .clk(clk), .rst(rst), .hostAcc(hostAcc), .hostWrite(hostWrite),
    .hostRank(hostRank), .hostCe(hostCe), .cfgWe(cfgWe),
    .cfgThreshold(cfgThreshold), .strobe(strobe), .copyRdAddr(copyRdAddr),
    .copyWrAddr(copyWrAddr), .victim(victim), .hostReady(hostReady),
    .ceAlert(ceAlert), .spareUsed(spareUsed), .spentFlag(spentFlag)
  );

  spare_dp #(
    .NUM_RANKS(NUM_RANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RANK_W(RANK_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .copyRdAddr(copyRdAddr),
    .copyWrAddr(copyWrAddr), .victim(victim), .hostAcc(hostAcc),
    .hostWrite(hostWrite), .hostRank(hostRank), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRvalid(hostRvalid)
  );

endmodule

// File: tb/sim_spare_rank_ctrl.sv
module sim_spare_rank_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostValid = 1'b0, hostWrite = 1'b0, hostCe = 1'b0, cfgWe = 1'b0;
  logic [1:0] hostRank = '0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [CW-1:0] cfgThreshold = '0;
  logic hostReady, hostRvalid, ceAlert, spareUsed, spentFlag;
  logic [DW-1:0] hostRdata;
  logic [1:0] failedRank;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] model [NR][DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  spare_rank_ctrl #(.NUM_RANKS(NR), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .THRESH_INIT(3)) u0 (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostRank(hostRank), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostCe(hostCe), .hostReady(hostReady), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .cfgWe(cfgWe), .cfgThreshold(cfgThreshold),
    .ceAlert(ceAlert), .spareUsed(spareUsed), .failedRank(failedRank),
    .spentFlag(spentFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, wait for ready, return on the falling edge after acceptance
  task automatic access(input bit wr, input int rk, input int ad, input logic [DW-1:0] wd, input bit ce);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostRank = 2'(rk);
    hostAddr = AW'(ad); hostWdata = wd; hostCe = ce;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostValid = 1'b0; hostCe = 1'b0;
    if (wr) model[rk][ad] = wd;
  endtask

  task automatic readCheck(input string req, input int rk, input int ad, input bit ce);
    access(1'b0, rk, ad, '0, ce);
    chk({req, " rvalid"}, 32'(hostRvalid), 32'd1);
    chk({req, " rdata"}, 32'(hostRdata), 32'(model[rk][ad]));
  endtask

  task automatic setThr(input int v);
    @(negedge clk);
    cfgWe = 1'b1; cfgThreshold = CW'(v);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [DW-1:0] mix(input int rk, input int ad);
    return DW'($urandom) ^ DW'(rk * 4099 + ad * 17);
  endfunction

  initial begin
    int stall;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 hostReady", 32'(hostReady), 32'd1);
    chk("R1 ceAlert", 32'(ceAlert), 32'd0);
    chk("R1 spareUsed", 32'(spareUsed), 32'd0);
    chk("R1 spentFlag", 32'(spentFlag), 32'd0);
    chk("R1 hostRvalid", 32'(hostRvalid), 32'd0);

    // R2 fill every location, then random reads
    for (int r = 0; r < NR; r++)
      for (int a = 0; a < DEPTH; a++)
        access(1'b1, r, a, mix(r, a), 1'b0);
    for (int i = 0; i < 30; i++) begin
      int r = int'($urandom % NR);
      int a = int'($urandom % DEPTH);
      readCheck("R2 random read", r, a, 1'b0);
    end
    // write-then-read at the extreme addresses
    access(1'b1, 3, DEPTH-1, 16'hFFFF, 1'b0);
    readCheck("R2 top address", 3, DEPTH-1, 1'b0);
    access(1'b1, 0, 0, 16'h0000, 1'b0);
    readCheck("R2 address zero", 0, 0, 1'b0);

    // R3 flagged writes must not count
    for (int i = 0; i < 8; i++) access(1'b1, 0, i, mix(0, i), 1'b1);
    @(negedge clk);
    chk("R3 ce on writes ignored", 32'(ceAlert), 32'd0);
    chk("R3 no migration after writes", 32'(hostReady), 32'd1);

    // R4 equal to the threshold (3) does not trigger
    for (int i = 0; i < 3; i++) readCheck("R3 ce read", 2, i, 1'b1);
    @(negedge clk);
    chk("R4 count equal threshold no alert", 32'(ceAlert), 32'd0);
    chk("R4 count equal threshold no switch", 32'(spareUsed), 32'd0);

    // R5/R6 raise the threshold to the maximum, overdrive rank 1
    setThr(15);
    for (int i = 0; i < 20; i++) readCheck("R5 ce read", 1, i % DEPTH, 1'b1);
    @(negedge clk);
    chk("R5 saturated count not above max", 32'(ceAlert), 32'd0);
    chk("R5 still ready", 32'(hostReady), 32'd1);

    // R6/R8 lower threshold to 14: saturated count 15 now exceeds it
    setThr(14);
    chk("R8 ready still high in crossing cycle", 32'(hostReady), 32'd1);
    stall = 0;
    @(negedge clk);
    chk("R7 alert one cycle after crossing", 32'(ceAlert), 32'd1);
    chk("R6 new threshold used next cycle", 32'(hostReady), 32'd0);
    while (!hostReady && stall < 1000) begin
      stall++;
      @(negedge clk);
    end
    chk("R8 stall length", 32'(stall), 32'(DEPTH + 1));
    chk("R9 spareUsed", 32'(spareUsed), 32'd1);
    chk("R9 failedRank lowest crossing", 32'(failedRank), 32'd1);
    chk("R10 spentFlag clear after first", 32'(spentFlag), 32'd0);
    chk("R7 alert sticky", 32'(ceAlert), 32'd1);

    // R9 all data preserved through the migration
    for (int r = 0; r < NR; r++)
      for (int a = 0; a < DEPTH; a++)
        readCheck("R9 data after migration", r, a, 1'b0);
    // R9 random traffic with the spare in place
    for (int i = 0; i < 40; i++) begin
      int r = int'($urandom % NR);
      int a = int'($urandom % DEPTH);
      if ($urandom % 2 == 0) access(1'b1, r, a, mix(r, a), 1'b0);
      else readCheck("R9 random after switch", r, a, 1'b0);
    end
    for (int a = 0; a < DEPTH; a++) readCheck("R9 remapped rank sweep", 1, a, 1'b0);

    // R10 second crossing: rank 2 holds count 3, threshold 2
    setThr(2);
    chk("R10 no stall on second crossing", 32'(hostReady), 32'd1);
    @(negedge clk);
    chk("R10 spentFlag set", 32'(spentFlag), 32'd1);
    chk("R10 still ready", 32'(hostReady), 32'd1);
    chk("R10 failedRank unchanged", 32'(failedRank), 32'd1);
    chk("R10 spareUsed kept", 32'(spareUsed), 32'd1);
    readCheck("R10 data intact", 2, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 spentFlag sticky", 32'(spentFlag), 32'd1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule